// File: doc/BRIEF.md
# Timeslot Bit Selector for One Channel

This block extracts the bits of a single logical channel from a set of framed serial TDM links. It also marks the same positions for the transmit side. All links share one position counter. The counter gives the timeslot number and the bit position inside that timeslot, and a separate input says whether the current frame is odd or even. Each link has its own frame-alignment flag. Configuration names one link and one timeslot on it. It also gives an 8-bit mask that picks any subset of that timeslot's bits, and a frame selector that limits the channel to odd frames, even frames, both, or none.

On the receive side, every selected bit appears on `rx_bit` with a one-cycle strobe `rx_valid`. On the transmit side, `tx_req` asks the channel source for a bit one clock before each selected position. During that position, the supplied `tx_bit` is driven onto the chosen link's output lane together with an enable. Configuration inputs are sampled only on the last bit of a frame, so a change never splits a frame between two setups. Recovering frame alignment is the job of the framer upstream.

Top module: `tsel_channel_pick`

## Requirements
- R1: After reset the active setup is "channel off": `rx_valid`, `rx_bit`, `tx_line_en` and `tx_line` are 0, and no bit is selected until a frame end has loaded the configuration inputs.
- R2: A position is selected when all of the following hold: `pos_slot` equals the active timeslot, the active mask bit indexed by `pos_bit` is 1, the frame selector permits the current frame, and the active link is aligned. On the clock after a selected position, `rx_valid` is 1 and `rx_bit` holds that position's bit from the active link. Otherwise both are 0.
- R3: Bits are counted first-sent first: `pos_bit` 0 is the first bit of a timeslot and is matched by mask bit 0, and `pos_bit` 7 is matched by mask bit 7. Any combination of mask bits is allowed.
- R4: The frame selector encoding is 2'b01 for odd frames only (`frame_odd`=1), 2'b10 for even frames only (`frame_odd`=0), 2'b11 for every frame, and 2'b00 for channel off.
- R5: While the active link's alignment flag is 0, no position is selected: `rx_valid`, `tx_req` and `tx_line_en` stay 0. The alignment flags of other links have no effect.
- R6: The configuration inputs are captured on the clock edge at which `pos_slot` = SLOTS-1 and `pos_bit` = 7. The captured setup governs selection from the next frame's first bit onward. Changes made at any other time have no effect on the current frame.
- R7: `tx_req` is 1 in the cycle just before each position that will be selected. Across a frame end, it uses the configuration inputs about to be captured and the inverted frame parity.
- R8: During a selected position, exactly `tx_line_en[link]` of the active link is 1 and `tx_line[link]` equals `tx_bit`. All other lane bits are 0.
- R9: Data on links other than the active one never reaches `rx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_bit | input | NUM_LINKS | Receive serial bit of each link |
| link_aligned | input | NUM_LINKS | Frame-alignment flag of each link |
| pos_slot | input | SLOT_W | Current timeslot number |
| pos_bit | input | 3 | Current bit inside the timeslot, 0 = first sent |
| frame_odd | input | 1 | 1 in odd frames, 0 in even frames |
| cfg_link | input | LINK_W | Link carrying the channel |
| cfg_slot | input | SLOT_W | Timeslot carrying the channel |
| cfg_mask | input | 8 | Bit-select mask, bit i matches `pos_bit` i |
| cfg_frames | input | 2 | Frame selector (01 odd, 10 even, 11 both, 00 off) |
| rx_valid | output | 1 | Strobe for a selected receive bit |
| rx_bit | output | 1 | Selected receive bit |
| tx_req | output | 1 | Request for the next transmit bit |
| tx_bit | input | 1 | Transmit bit supplied after a request |
| tx_line | output | NUM_LINKS | Transmit bit per link lane |
| tx_line_en | output | NUM_LINKS | Lane enable, one-hot during a selected position |

## Verification
`tx_req`, `tx_line_en` and `tx_line` are combinational functions of the current position inputs, so the bench checks them halfway through the same cycle in which it drives those inputs. `rx_valid` and `rx_bit` pass through one register, so for each position they are checked one nanosecond after the following rising edge. The bench then updates its own copy of the active setup, but only after an edge at which the last bit of a frame was present. Per-frame counts of strobes, requests and lane enables are compared with totals worked out by hand from the masks and selectors.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int BITS_PER_SLOT = 8;
    localparam int BIT_W         = 3;

    typedef enum logic [1:0] {
        FSEL_OFF  = 2'b00,
        FSEL_ODD  = 2'b01,
        FSEL_EVEN = 2'b10,
        FSEL_BOTH = 2'b11
    } frame_sel_e;

    typedef struct packed {
        logic [BITS_PER_SLOT-1:0] mask;
        frame_sel_e               fsel;
    } sel_rule_t;

    function automatic logic frame_permits(frame_sel_e sel, logic odd);
        case (sel)
            FSEL_ODD:  return odd;
            FSEL_EVEN: return !odd;
            FSEL_BOTH: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic is_last_bit(logic [BIT_W-1:0] b);
        return b == BIT_W'(BITS_PER_SLOT - 1);
    endfunction

endpackage

// File: rtl/tsel_shadow.sv
module tsel_shadow
    import tsel_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int LINK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINK_W-1:0] in_link,
    input  logic [SLOT_W-1:0] in_slot,
    input  sel_rule_t         in_rule,
    output logic [LINK_W-1:0] act_link,
    output logic [SLOT_W-1:0] act_slot,
    output sel_rule_t         act_rule
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_link      <= '0;
            act_slot      <= '0;
            act_rule.mask <= '0;
            act_rule.fsel <= FSEL_OFF;
        end else if (load) begin
            act_link <= in_link;
            act_slot <= in_slot;
            act_rule <= in_rule;
        end
    end

endmodule

// File: rtl/tsel_match.sv
module tsel_match
    import tsel_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int SLOT_W    = 5,
    parameter int LINK_W    = 2
) (
    input  logic [SLOT_W-1:0]    pos_slot,
    input  logic [BIT_W-1:0]     pos_bit,
    input  logic                 odd,
    input  logic [NUM_LINKS-1:0] aligned,
    input  logic [LINK_W-1:0]    chan_link,
    input  logic [SLOT_W-1:0]    chan_slot,
    input  sel_rule_t            rule,
    output logic                 hit
);

    logic link_ok;

    always_comb begin
        link_ok = 1'b0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (chan_link == LINK_W'(i)) link_ok = aligned[i];
        end
        hit = link_ok
            && (pos_slot == chan_slot)
            && rule.mask[pos_bit]
            && frame_permits(rule.fsel, odd);
    end

endmodule

// File: rtl/tsel_rx_capture.sv
module tsel_rx_capture #(
    parameter int NUM_LINKS = 4,
    parameter int LINK_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    input  logic [LINK_W-1:0]    chan_link,
    input  logic [NUM_LINKS-1:0] lanes,
    output logic                 rx_valid,
    output logic                 rx_bit
);

    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (chan_link == LINK_W'(i)) picked = lanes[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            rx_valid <= hit;
            rx_bit   <= hit & picked;
        end
    end

endmodule

// File: rtl/tsel_channel_pick.sv
module tsel_channel_pick
    import tsel_pkg::*;
#(
    parameter int  NUM_LINKS = 4,
    parameter int  SLOTS     = 32,
    localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LINK_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINKS-1:0] link_bit,
    input  logic [NUM_LINKS-1:0] link_aligned,
    input  logic [SLOT_W-1:0]    pos_slot,
    input  logic [2:0]           pos_bit,
    input  logic                 frame_odd,
    input  logic [LINK_W-1:0]    cfg_link,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [7:0]           cfg_mask,
    input  logic [1:0]           cfg_frames,
    output logic                 rx_valid,
    output logic                 rx_bit,
    output logic                 tx_req,
    input  logic                 tx_bit,
    output logic [NUM_LINKS-1:0] tx_line,
    output logic [NUM_LINKS-1:0] tx_line_en
);

    sel_rule_t         in_rule;
    sel_rule_t         act_rule;
    sel_rule_t         nxt_rule;
    logic [LINK_W-1:0] act_link;
    logic [LINK_W-1:0] nxt_link;
    logic [SLOT_W-1:0] act_slot;
    logic [SLOT_W-1:0] nxt_chan_slot;
    logic [SLOT_W-1:0] nxt_pos_slot;
    logic [BIT_W-1:0]  nxt_pos_bit;
    logic              nxt_odd;
    logic              frame_end;
    logic              cur_hit;

    assign in_rule.mask = cfg_mask;
    assign in_rule.fsel = frame_sel_e'(cfg_frames);

    // Last bit of the last timeslot: the configuration is sampled here.
    assign frame_end = (pos_slot == SLOT_W'(SLOTS - 1)) && is_last_bit(pos_bit);

    tsel_shadow #(.SLOT_W(SLOT_W), .LINK_W(LINK_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_end),
        .in_link  (cfg_link),
        .in_slot  (cfg_slot),
        .in_rule  (in_rule),
        .act_link (act_link),
        .act_slot (act_slot),
        .act_rule (act_rule)
    );

    // Selection at the current position.
    tsel_match #(.NUM_LINKS(NUM_LINKS), .SLOT_W(SLOT_W), .LINK_W(LINK_W)) u_cur (
        .pos_slot  (pos_slot),
        .pos_bit   (pos_bit),
        .odd       (frame_odd),
        .aligned   (link_aligned),
        .chan_link (act_link),
        .chan_slot (act_slot),
        .rule      (act_rule),
        .hit       (cur_hit)
    );

    // Position and setup one clock ahead, for the transmit request.
    always_comb begin
        nxt_pos_bit = pos_bit + BIT_W'(1);
        if (!is_last_bit(pos_bit))  nxt_pos_slot = pos_slot;
        else if (frame_end)         nxt_pos_slot = '0;
        else                        nxt_pos_slot = pos_slot + SLOT_W'(1);
        nxt_odd       = frame_end ? !frame_odd : frame_odd;
        nxt_link      = frame_end ? cfg_link   : act_link;
        nxt_chan_slot = frame_end ? cfg_slot   : act_slot;
        nxt_rule      = frame_end ? in_rule    : act_rule;
    end

    tsel_match #(.NUM_LINKS(NUM_LINKS), .SLOT_W(SLOT_W), .LINK_W(LINK_W)) u_ahead (
        .pos_slot  (nxt_pos_slot),
        .pos_bit   (nxt_pos_bit),
        .odd       (nxt_odd),
        .aligned   (link_aligned),
        .chan_link (nxt_link),
        .chan_slot (nxt_chan_slot),
        .rule      (nxt_rule),
        .hit       (tx_req)
    );

    // One transmit lane per link.
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
        assign tx_line_en[g] = cur_hit && (act_link == LINK_W'(g));
        assign tx_line[g]    = tx_line_en[g] & tx_bit;
    end

    tsel_rx_capture #(.NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .hit       (cur_hit),
        .chan_link (act_link),
        .lanes     (link_bit),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit)
    );

endmodule

// File: rtl/tsel_channel_pick_chk.sv
module tsel_channel_pick_chk #(
    parameter int NUM_LINKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINKS-1:0] link_aligned,
    input logic                 rx_valid,
    input logic                 tx_req,
    input logic [NUM_LINKS-1:0] tx_line,
    input logic [NUM_LINKS-1:0] tx_line_en
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rx_valid && tx_line_en == '0)); // R1

    AST_EN_THEN_VALID: assert property (@(posedge clk) disable iff (rst)
        (tx_line_en != '0) |=> rx_valid); // R2

    AST_VALID_HAD_EN: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(tx_line_en) != '0)); // R2

    AST_UNALIGNED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (link_aligned == '0) |-> (!tx_req && tx_line_en == '0)); // R5

    AST_REQ_LEADS_SLOT: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> ((tx_line_en != '0) || (link_aligned != $past(link_aligned)))); // R7

    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_line_en)); // R8

    AST_LINE_GATED: assert property (@(posedge clk) disable iff (rst)
        (tx_line & ~tx_line_en) == '0); // R8

endmodule

bind tsel_channel_pick tsel_channel_pick_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .link_aligned (link_aligned),
    .rx_valid     (rx_valid),
    .tx_req       (tx_req),
    .tx_line      (tx_line),
    .tx_line_en   (tx_line_en)
);

// File: tb/tsel_channel_pick_tb.sv
module tsel_channel_pick_tb;

    localparam int NL    = 4;
    localparam int NS    = 32;
    localparam int SW    = 5;
    localparam int LW    = 2;
    localparam int FRAME = NS * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] link_bit, link_aligned, tx_line, tx_line_en;
    logic [SW-1:0] pos_slot, cfg_slot;
    logic [2:0]    pos_bit;
    logic          frame_odd, rx_valid, rx_bit, tx_req, tx_bit;
    logic [LW-1:0] cfg_link;
    logic [7:0]    cfg_mask;
    logic [1:0]    cfg_frames;

    always #5 clk = ~clk;

    tsel_channel_pick #(.NUM_LINKS(NL), .SLOTS(NS)) u_dut (
        .clk(clk), .rst(rst), .link_bit(link_bit), .link_aligned(link_aligned),
        .pos_slot(pos_slot), .pos_bit(pos_bit), .frame_odd(frame_odd),
        .cfg_link(cfg_link), .cfg_slot(cfg_slot), .cfg_mask(cfg_mask),
        .cfg_frames(cfg_frames), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .tx_req(tx_req), .tx_bit(tx_bit), .tx_line(tx_line), .tx_line_en(tx_line_en)
    );

    int   checks = 0;
    int   errors = 0;
    int   b_slot = 0;
    int   b_bit  = 0;
    logic b_odd  = 1'b1;
    logic invert_others = 1'b0;
    int   cnt_valid, cnt_req, cnt_en3;

    // Bench copy of the active setup (R1: off after reset).
    int         m_link = 0;
    int         m_slot = 0;
    logic [7:0] m_mask = 8'h00;
    logic [1:0] m_fsel = 2'b00;

    function automatic logic pat(int l, int s, int b, logic o);
        return ((l * 5 + s * 7 + b * 3 + int'(o)) % 3) == 0;
    endfunction

    function automatic logic sel_m(int l, int s, logic [7:0] m, logic [1:0] f,
                                   int ps, int pb, logic odd, logic [NL-1:0] al);
        logic fo;
        fo = (f == 2'b11) || (f == 2'b01 && odd) || (f == 2'b10 && !odd);
        return fo && (l < NL) && al[l] && (s == ps) && m[pb];
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b (slot %0d bit %0d)", tag, act, exp, b_slot, b_bit);
        end
    endtask

    task automatic chkv(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b (slot %0d bit %0d)", tag, act, exp, b_slot, b_bit);
        end
    endtask

    task automatic chk_count(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(int l, int s, logic [7:0] m, logic [1:0] f);
        cfg_link   = LW'(l);
        cfg_slot   = SW'(s);
        cfg_mask   = m;
        cfg_frames = f;
    endtask

    // Advance n positions; called and returning 1 ns after a rising edge.
    task automatic run(int n);
        cnt_valid = 0; cnt_req = 0; cnt_en3 = 0;
        for (int k = 0; k < n; k++) begin
            logic          cur, last, exp_req, exp_rb, n_odd;
            int            n_slot, n_bit, nl, ns_;
            logic [7:0]    nm;
            logic [1:0]    nf;
            logic [NL-1:0] exp_en;
            pos_slot  = SW'(b_slot);
            pos_bit   = 3'(b_bit);
            frame_odd = b_odd;
            for (int l = 0; l < NL; l++)
                link_bit[l] = pat(l, b_slot, b_bit, b_odd) ^ (invert_others && l != m_link);
            tx_bit = k[0] ^ b_odd;
            #4;
            cur  = sel_m(m_link, m_slot, m_mask, m_fsel, b_slot, b_bit, b_odd, link_aligned);
            last = (b_slot == NS - 1) && (b_bit == 7);
            n_bit  = (b_bit + 1) % 8;
            n_slot = (b_bit == 7) ? ((b_slot + 1) % NS) : b_slot;
            n_odd  = last ? !b_odd : b_odd;
            nl  = last ? int'(cfg_link) : m_link;
            ns_ = last ? int'(cfg_slot) : m_slot;
            nm  = last ? cfg_mask : m_mask;
            nf  = last ? cfg_frames : m_fsel;
            exp_req = sel_m(nl, ns_, nm, nf, n_slot, n_bit, n_odd, link_aligned);
            chk("R7 tx_req", tx_req, exp_req);
            exp_en = cur ? NL'(1 << m_link) : '0;
            chkv("R8 tx_line_en", tx_line_en, exp_en);
            chkv("R8 tx_line", tx_line, exp_en & {NL{tx_bit}});
            cnt_req += int'(tx_req);
            cnt_en3 += int'(tx_line_en[3]);
            exp_rb = cur ? link_bit[m_link] : 1'b0;
            @(posedge clk);
            #1;
            chk("R2 rx_valid", rx_valid, cur);
            chk("R2 rx_bit", rx_bit, exp_rb);
            cnt_valid += int'(rx_valid);
            if (last) begin
                m_link = int'(cfg_link); m_slot = int'(cfg_slot);
                m_mask = cfg_mask;       m_fsel = cfg_frames;
            end
            b_bit = n_bit; b_slot = n_slot; b_odd = n_odd;
        end
    endtask

    task automatic run_rest();
        run(FRAME - (b_slot * 8 + b_bit));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        link_aligned = '1; link_bit = '0; tx_bit = 1'b0;
        pos_slot = '0; pos_bit = '0; frame_odd = 1'b1;
        set_cfg(0, 0, 8'hFF, 2'b11);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #4;
        chk("R1 rx_valid after reset", rx_valid, 1'b0);
        chkv("R1 tx_line_en after reset", tx_line_en, '0);
        @(posedge clk);
        #1;
        run(8); // slot 0 bits: configured but not yet loaded
        chk_count("R1 no strobes before first frame end", cnt_valid, 0);
        run_rest();
        run(FRAME);
        chk_count("R6 setup active after frame end", cnt_valid, 8);
    endtask

    task automatic t_mask();
        set_cfg(1, 5, 8'hA5, 2'b11);
        run_rest();
        run(2 * FRAME);
        chk_count("R3 mask A5 strobes over two frames", cnt_valid, 8);
        set_cfg(2, NS - 1, 8'h80, 2'b11);
        run_rest();
        run(FRAME);
        chk_count("R3 mask bit 7 in last slot", cnt_valid, 1);
        set_cfg(0, 0, 8'h01, 2'b11);
        run_rest();
        run(FRAME);
        chk_count("R3 mask bit 0 in slot 0", cnt_valid, 1);
    endtask

    task automatic t_parity();
        set_cfg(1, 9, 8'hFF, 2'b01);
        run_rest();
        run(2 * FRAME);
        chk_count("R4 odd frames only", cnt_valid, 8);
        set_cfg(1, 9, 8'hFF, 2'b10);
        run_rest();
        run(2 * FRAME);
        chk_count("R4 even frames only", cnt_valid, 8);
        set_cfg(1, 9, 8'hFF, 2'b00);
        run_rest();
        run(FRAME);
        chk_count("R4 selector off", cnt_valid, 0);
    endtask

    task automatic t_align();
        set_cfg(2, 3, 8'hFF, 2'b11);
        run_rest();
        link_aligned = 4'b1011;
        run(FRAME);
        chk_count("R5 no strobes while unaligned", cnt_valid, 0);
        chk_count("R5 no requests while unaligned", cnt_req, 0);
        link_aligned = 4'b0100;
        run(FRAME);
        chk_count("R5 other links unaligned ignored", cnt_valid, 8);
        link_aligned = '1;
    endtask

    task automatic t_boundary();
        set_cfg(0, 10, 8'hFF, 2'b11);
        run_rest();
        run(88);
        chk_count("R6 first setup in slot 10", cnt_valid, 8);
        set_cfg(0, 20, 8'h0F, 2'b11);
        run_rest();
        chk_count("R6 mid-frame change not applied", cnt_valid, 0);
        run(FRAME);
        chk_count("R6 new setup after frame end", cnt_valid, 4);
        set_cfg(0, 0, 8'h01, 2'b11);
        run(FRAME);
        chk_count("R7 requests include lookahead across frame end", cnt_req, 5);
        run(FRAME);
        chk_count("R7 one request per frame for slot 0 bit 0", cnt_req, 1);
        chk_count("R7 one strobe per frame for slot 0 bit 0", cnt_valid, 1);
    endtask

    task automatic t_isolation();
        set_cfg(3, 7, 8'hFF, 2'b11);
        run_rest();
        invert_others = 1'b1;
        run(FRAME);
        chk_count("R9 strobes on link 3", cnt_valid, 8);
        chk_count("R8 lane 3 enables", cnt_en3, 8);
        invert_others = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_mask();
        t_parity();
        t_align();
        t_boundary();
        t_isolation();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule